// File: doc/BRIEF.md
# Infrared Carrier Modulator

This block produces the modulated carrier for an infrared remote-control transmitter. It divides the system clock with one shared period counter. A two-bit shape select picks one of three carrier waveforms, or a plain mode with no carrier. When a carrier shape is active, a gate input turns the carrier on and off at the output pin. In the plain mode, the same pin serves as a one-bit registered output port that follows a data input.

The output pin is registered, so it changes one clock after the inputs that decide it. A new shape select waits for the end of the current carrier period before it takes over, so a pulse is never cut short. The counter stays at zero while the gate is low. When the gate opens, the first pulse starts with a complete high phase. All inputs are plain level controls. There is no data stream at the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `ir_carrier_gen`

## Requirements
- R1: Shape select 2'b00 with the gate high gives a carrier of period 12 clocks, high for the first 4 clocks of each period.
- R2: Shape select 2'b01 with the gate high gives a carrier of period 12 clocks, high for the first 3 clocks of each period.
- R3: Shape select 2'b10 with the gate high gives a carrier of period 8 clocks, high for the first 4 clocks of each period.
- R4: Shape select 2'b11 carries no carrier. On each clock, `pin_out` takes the value that `latch_d` had in the previous cycle, and `carrier_en` has no effect.
- R5: In a carrier shape, while `carrier_en` is low, `pin_out` is low one clock later, whatever the value of `latch_d`.
- R6: When `carrier_en` is sampled high after being low, `pin_out` is high on the next clock and stays high for the full high phase of the active shape.
- R7: A change of `shape_sel` made during a carrier period does not alter that period. The new shape starts with the first clock of the following period.
- R8: A synchronous reset drives `pin_out` low and sets the active shape to 2'b00. If the gate is high as reset is released, the first period follows the 2'b00 shape, even when another shape is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that the carrier is divided from |
| rst | input | 1 | Synchronous reset, active high |
| shape_sel | input | 2 | Requested carrier shape (00, 01, 10 carriers; 11 plain) |
| carrier_en | input | 1 | Gate for the carrier in the carrier shapes |
| latch_d | input | 1 | Data bit shown on the pin in the plain mode |
| pin_out | output | 1 | Registered output pin |

## Verification
The case that matters most is a shape request that is still waiting while the period counter reaches its last count. On that same clock, the old shape must produce its final low sample and the new shape must be loaded. The bench raises the gate, switches `shape_sel` in the middle of a period, and compares every following sample against the old pattern up to the boundary and the new pattern after it. A second collision is reset release with the gate already high and a different shape selected. There the reset shape has to govern one full period before the requested shape is loaded.

// File: rtl/ir_carrier_gen_pkg.sv
package ir_carrier_gen_pkg;

  typedef enum logic [1:0] {
    SHAPE_THIRD = 2'b00,
    SHAPE_QUART = 2'b01,
    SHAPE_HALF  = 2'b10,
    SHAPE_PLAIN = 2'b11
  } shape_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ir_shape_decode.sv
module ir_shape_decode
  import ir_carrier_gen_pkg::*;
#(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned PER_THIRD = 12,
  parameter int unsigned HI_THIRD  = 4,
  parameter int unsigned PER_QUART = 12,
  parameter int unsigned HI_QUART  = 3,
  parameter int unsigned PER_HALF  = 8,
  parameter int unsigned HI_HALF   = 4
) (
  input  shape_e             shape,
  input  logic [CNT_W-1:0]   cnt,
  output logic               period_last,
  output logic               high_phase
);
  localparam logic [CNT_W-1:0] LAST_THIRD = CNT_W'(PER_THIRD - 1);
  localparam logic [CNT_W-1:0] LAST_QUART = CNT_W'(PER_QUART - 1);
  localparam logic [CNT_W-1:0] LAST_HALF  = CNT_W'(PER_HALF - 1);
  localparam logic [CNT_W-1:0] TOP_THIRD  = CNT_W'(HI_THIRD);
  localparam logic [CNT_W-1:0] TOP_QUART  = CNT_W'(HI_QUART);
  localparam logic [CNT_W-1:0] TOP_HALF   = CNT_W'(HI_HALF);

  // Plain mode counts as a permanent boundary: the shape may change any clock.
  always_comb begin
    unique case (shape)
      SHAPE_THIRD: begin
        period_last = (cnt == LAST_THIRD);
        high_phase  = (cnt < TOP_THIRD);
      end
      SHAPE_QUART: begin
        period_last = (cnt == LAST_QUART);
        high_phase  = (cnt < TOP_QUART);
      end
      SHAPE_HALF: begin
        period_last = (cnt == LAST_HALF);
        high_phase  = (cnt < TOP_HALF);
      end
      default: begin
        period_last = 1'b1;
        high_phase  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ir_period_counter.sv
module ir_period_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ir_shape_stage.sv
module ir_shape_stage
  import ir_carrier_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] shape_req,
  output shape_e     shape
);
  always_ff @(posedge clk) begin
    if (rst)       shape <= SHAPE_THIRD;
    else if (load) shape <= shape_e'(shape_req);
  end
endmodule

// File: rtl/ir_pin_drive.sv
module ir_pin_drive
  import ir_carrier_gen_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  shape_e shape,
  input  logic   gate,
  input  logic   high_phase,
  input  logic   data_bit,
  output logic   pin
);
  always_ff @(posedge clk) begin
    if (rst)                      pin <= 1'b0;
    else if (shape == SHAPE_PLAIN) pin <= data_bit;
    else                          pin <= gate & high_phase;
  end
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
  import ir_carrier_gen_pkg::*;
#(
  parameter int unsigned PER_THIRD = 12,
  parameter int unsigned HI_THIRD  = 4,
  parameter int unsigned PER_QUART = 12,
  parameter int unsigned HI_QUART  = 3,
  parameter int unsigned PER_HALF  = 8,
  parameter int unsigned HI_HALF   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] shape_sel,
  input  logic       carrier_en,
  input  logic       latch_d,
  output logic       pin_out
);
  localparam int unsigned MAX_PER = max3(PER_THIRD, PER_QUART, PER_HALF);
  localparam int unsigned CNT_W   = (MAX_PER > 2) ? $clog2(MAX_PER) : 1;

  logic [CNT_W-1:0] cnt;
  shape_e           act_shape;
  logic             period_last;
  logic             high_phase;
  logic             boundary;

  // Gate low holds the counter at zero, so reopening starts a full period.
  assign boundary = !carrier_en || period_last;

  ir_shape_decode #(
    .CNT_W(CNT_W),
    .PER_THIRD(PER_THIRD), .HI_THIRD(HI_THIRD),
    .PER_QUART(PER_QUART), .HI_QUART(HI_QUART),
    .PER_HALF(PER_HALF),   .HI_HALF(HI_HALF)
  ) u_decode (
    .shape(act_shape), .cnt(cnt),
    .period_last(period_last), .high_phase(high_phase)
  );

  ir_period_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .restart(boundary), .cnt(cnt)
  );

  ir_shape_stage u_shape (
    .clk(clk), .rst(rst), .load(boundary),
    .shape_req(shape_sel), .shape(act_shape)
  );

  ir_pin_drive u_pin (
    .clk(clk), .rst(rst), .shape(act_shape), .gate(carrier_en),
    .high_phase(high_phase), .data_bit(latch_d), .pin(pin_out)
  );
endmodule

// File: rtl/ir_carrier_gen_chk.sv
module ir_carrier_gen_chk #(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned MAX_PER = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             carrier_en,
  input logic             latch_d,
  input logic             pin_out,
  input logic [CNT_W-1:0] cnt,
  input logic [1:0]       act_shape
);
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(MAX_PER));

  assert_plain_follows_R4: assert property (@(posedge clk) disable iff (rst)
    (act_shape == 2'b11) |=> (pin_out == $past(latch_d)));

  assert_gate_low_R5: assert property (@(posedge clk) disable iff (rst)
    (act_shape != 2'b11 && !carrier_en) |=> !pin_out);

  assert_gate_open_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(carrier_en) && act_shape != 2'b11) |=> pin_out);

  assert_switch_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_shape) |-> (cnt == '0));

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (act_shape == 2'b00 && !pin_out));
endmodule

bind ir_carrier_gen ir_carrier_gen_chk #(.CNT_W(CNT_W), .MAX_PER(MAX_PER)) u_chk (
  .clk(clk), .rst(rst), .carrier_en(carrier_en), .latch_d(latch_d),
  .pin_out(pin_out), .cnt(cnt), .act_shape(act_shape)
);

// File: tb/ir_carrier_gen_tb_top.sv
module ir_carrier_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] shape_sel = 2'b00;
  logic       carrier_en = 1'b0;
  logic       latch_d = 1'b0;
  logic       pin_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ir_carrier_gen dut_i (
    .clk(clk), .rst(rst), .shape_sel(shape_sel),
    .carrier_en(carrier_en), .latch_d(latch_d), .pin_out(pin_out)
  );

  // Table: shape code, period, high clocks, requirement tag
  localparam int NROW = 3;
  localparam logic [1:0] V_SHAPE[NROW] = '{2'b00, 2'b01, 2'b10};
  localparam int         V_PER  [NROW] = '{12, 12, 8};
  localparam int         V_HI   [NROW] = '{4, 3, 4};
  localparam string      V_TAG  [NROW] = '{"R1", "R2", "R3"};

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pin_out=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    // Reset state (R8)
    repeat (3) @(negedge clk);
    chk("R8_reset_low", pin_out, 1'b0);
    rst = 1'b0;

    // Table walk: R1, R2, R3, first pulse of each (R6)
    for (int r = 0; r < NROW; r++) begin
      @(negedge clk);
      carrier_en = 1'b0;
      shape_sel  = V_SHAPE[r];
      repeat (2) @(negedge clk);
      carrier_en = 1'b1;
      for (int i = 0; i < 2 * V_PER[r]; i++) begin
        @(negedge clk);
        chk(V_TAG[r], pin_out, logic'((i % V_PER[r]) < V_HI[r]));
      end
    end

    // R5: gate low in a carrier shape holds the pin low despite latch_d
    carrier_en = 1'b0;
    shape_sel  = 2'b00;
    latch_d    = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R5", pin_out, 1'b0);
      latch_d = ~latch_d;
    end

    // R6: gate dropped in a high phase, then reopened gives a full high phase
    carrier_en = 1'b1;
    repeat (2) @(negedge clk);
    carrier_en = 1'b0;
    @(negedge clk);
    chk("R6_drop", pin_out, 1'b0);
    carrier_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R6", pin_out, logic'(i < 4));
    end

    // R7: shape change mid-period waits for the boundary
    carrier_en = 1'b0;
    shape_sel  = 2'b01;
    repeat (2) @(negedge clk);
    carrier_en = 1'b1;
    for (int i = 0; i < 28; i++) begin
      @(negedge clk);
      if (i < 12) chk("R7_old", pin_out, logic'(i < 3));
      else        chk("R7_new", pin_out, logic'(((i - 12) % 8) < 4));
      if (i == 5) shape_sel = 2'b10;
    end

    // R4: plain mode follows latch_d, gate ignored
    carrier_en = 1'b0;
    shape_sel  = 2'b11;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      latch_d    = logic'((i % 3) == 1);
      carrier_en = logic'(i[0]);
      @(negedge clk);
      chk("R4", pin_out, logic'((i % 3) == 1));
    end

    // R8: reset with gate high and shape 10 requested: one 00 period first
    rst        = 1'b1;
    carrier_en = 1'b1;
    shape_sel  = 2'b10;
    repeat (2) @(negedge clk);
    chk("R8_reset_low", pin_out, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i < 12) chk("R8_first", pin_out, logic'(i < 4));
      else        chk("R8_next", pin_out, logic'(((i - 12) % 8) < 4));
    end

    finish_run();
  end
endmodule